// File: doc/BRIEF.md
# Selectable-Tap Square-Wave Generator

A free-running 15-stage binary divider counts reference strobes from the timekeeping oscillator. One of its stage outputs is routed to a square-wave pin. Software picks the stage with a 4-bit rate code and switches the pin with an enable bit. Each of these is written through its own register write strobe. A power-fail input from the supply monitor forces the pin low whatever software has set, and reset clears both the enable and the rate.

The divider counts on every reference strobe, including while the pin is off. A re-enabled output therefore starts in phase with the counter. Software writes land in the registers at once and can be read back at once. The generator applies them only while its output is low, and it raises the pin only on a rising edge of the selected stage. Because of this it never emits a shortened high pulse.

Top module: `sqw_gen`

## Requirements
- R1: While rst_ni is low and on the first clock after it rises, sqw_o is 0, rate_o is 0 and sqw_en_o is 0.
- R2: The divider count advances by one on each clock with tick_i high and holds on clocks with tick_i low. It runs whatever the enable, rate and power-fail state.
- R3: Rate codes 3 to 15 select divider bit (code-2). The output period is 2^(code-1) strobes, with 2^(code-2) strobes high and the same number low, and the output follows the bit one clock after the strobe that moves it.
- R4: Rate codes 1 and 2 select the same divider bits as codes 8 and 9 (bits 6 and 7).
- R5: Rate code 0 holds sqw_o at 0.
- R6: With the enable bit at 0, sqw_o is held at 0.
- R7: With pwr_fail_i high at a clock edge, sqw_o is 0 after that edge, whatever the enable bit.
- R8: sqw_o only goes from 0 to 1 on a strobe where the selected divider bit goes from 0 to 1. After an enable, a rate change or the end of power-fail, the first high pulse is therefore always a full half period.
- R9: New rate or enable values are applied only on a clock where sqw_o is 0. A high phase in progress runs to its normal end under the old setting, unless power fails.
- R10: A clock with rate_we_i high loads rate_i into the rate register. A clock with ctrl_we_i high loads sqw_en_i into the enable register. rate_o and sqw_en_o show the register contents from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference oscillator strobe, one clock wide |
| rate_we_i | input | 1 | Write strobe for the rate register |
| rate_i | input | 4 | Rate code to write |
| ctrl_we_i | input | 1 | Write strobe for the enable register |
| sqw_en_i | input | 1 | Enable value to write |
| pwr_fail_i | input | 1 | Supply below the power-fail threshold |
| rate_o | output | 4 | Rate register readback |
| sqw_en_o | output | 1 | Enable register readback |
| sqw_o | output | 1 | Square-wave output |

## Verification
A bad divider count does not show at once. It appears at the next strobe that moves the selected bit: within two strobes for code 3, and only after up to 8192 strobes for code 15. Both the fastest and the slowest taps are therefore run for whole periods. A stale applied setting shows as a missed or misplaced edge as soon as the output next falls. A fault in the rise qualification shows as a short first pulse right after an enable or a power-fail release. The bench compares every output on every clock against a model that works in periods and phases, so each of these faults is caught at the first clock where it differs.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  localparam int unsigned RATE_W    = 4;
  localparam int unsigned CODES     = 1 << RATE_W;
  localparam int unsigned FIRST_TAP = 3;  // lowest code that maps straight to a stage
  localparam int unsigned ALIAS_OFS = 7;  // low codes reuse code+ALIAS_OFS

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              en;
  } sqw_cfg_t;

  // divider bit selected by a nonzero rate code
  function automatic int unsigned code_stage(int unsigned code);
    int unsigned eff;
    eff = (code < FIRST_TAP) ? code + ALIAS_OFS : code;
    return eff - 2;
  endfunction
endpackage

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int unsigned STAGES = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [STAGES-1:0] cnt_o,
  output logic [STAGES-1:0] cnt_nxt_o
);
  logic [STAGES-1:0] cnt_q;

  assign cnt_nxt_o = tick_i ? cnt_q + 1'b1 : cnt_q;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == $past(cnt_q) + 1'b1) else $error("cnt step");  // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)) else $error("cnt hold");  // R2
endmodule

// File: rtl/sqw_cfg_regs.sv
module sqw_cfg_regs
  import sqw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rate_we_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              ctrl_we_i,
  input  logic              sqw_en_i,
  output sqw_cfg_t          cfg_o
);
  sqw_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      if (rate_we_i) cfg_q.rate <= rate_i;
      if (ctrl_we_i) cfg_q.en   <= sqw_en_i;
    end
  end

  assign cfg_o = cfg_q;

  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> cfg_q.en == $past(sqw_en_i)) else $error("en write");  // R10
  AST_RATE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_we_i |=> cfg_q.rate == $past(rate_i)) else $error("rate write");  // R10
endmodule

// File: rtl/sqw_tap_sel.sv
module sqw_tap_sel
  import sqw_pkg::*;
#(
  parameter int unsigned STAGES = 15
) (
  input  logic [STAGES-1:0] cnt_i,
  input  logic [STAGES-1:0] cnt_nxt_i,
  input  logic [RATE_W-1:0] code_i,
  output logic              tap_cur_o,
  output logic              tap_nxt_o
);
  logic [CODES-1:0] cur_vec, nxt_vec;

  for (genvar c = 0; c < CODES; c++) begin : g_code
    if (c == 0) begin : g_off
      assign cur_vec[c] = 1'b0;
      assign nxt_vec[c] = 1'b0;
    end else if (code_stage(c) < STAGES) begin : g_tap
      localparam int unsigned ST = code_stage(c);
      assign cur_vec[c] = cnt_i[ST];
      assign nxt_vec[c] = cnt_nxt_i[ST];
    end else begin : g_none
      assign cur_vec[c] = 1'b0;
      assign nxt_vec[c] = 1'b0;
    end
  end

  assign tap_cur_o = cur_vec[code_i];
  assign tap_nxt_o = nxt_vec[code_i];
endmodule

// File: rtl/sqw_out_gate.sv
module sqw_out_gate
  import sqw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sqw_cfg_t          cfg_i,
  input  logic              pwr_fail_i,
  input  logic              tap_cur_i,
  input  logic              tap_nxt_i,
  output logic [RATE_W-1:0] act_rate_o,
  output logic              sqw_o
);
  sqw_cfg_t act_q, act_d;
  logic     sqw_q, sqw_d, on, rise;

  // setting is handed over only while the pin is low
  assign act_d      = sqw_q ? act_q : cfg_i;
  assign act_rate_o = act_d.rate;

  assign on    = act_d.en && !pwr_fail_i && (act_d.rate != '0);
  assign rise  = !tap_cur_i && tap_nxt_i;
  assign sqw_d = on && tap_nxt_i && (sqw_q || rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      sqw_q <= 1'b0;
    end else begin
      act_q <= act_d;
      sqw_q <= sqw_d;
    end
  end

  assign sqw_o = sqw_q;

  AST_PF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> !sqw_q) else $error("pf low");  // R7
  AST_RISE_ON_TAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sqw_q) |-> tap_cur_i) else $error("rise off tap");  // R8
  AST_CFG_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sqw_q |=> $stable(act_q)) else $error("cfg swap high");  // R9
  AST_CODE0_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q.rate == '0) |-> !sqw_q) else $error("code0");  // R5
  AST_DIS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q.en |-> !sqw_q) else $error("disabled");  // R6
endmodule

// File: rtl/sqw_gen.sv
module sqw_gen
  import sqw_pkg::*;
#(
  parameter int unsigned STAGES = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rate_we_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              ctrl_we_i,
  input  logic              sqw_en_i,
  input  logic              pwr_fail_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              sqw_en_o,
  output logic              sqw_o
);
  logic [STAGES-1:0] cnt, cnt_nxt;
  logic [RATE_W-1:0] act_rate;
  logic              tap_cur, tap_nxt;
  sqw_cfg_t          cfg;

  sqw_divider #(.STAGES(STAGES)) u_div (
    .clk_i, .rst_ni, .tick_i,
    .cnt_o(cnt), .cnt_nxt_o(cnt_nxt)
  );

  sqw_cfg_regs u_regs (
    .clk_i, .rst_ni, .rate_we_i, .rate_i, .ctrl_we_i, .sqw_en_i,
    .cfg_o(cfg)
  );

  sqw_tap_sel #(.STAGES(STAGES)) u_sel (
    .cnt_i(cnt), .cnt_nxt_i(cnt_nxt), .code_i(act_rate),
    .tap_cur_o(tap_cur), .tap_nxt_o(tap_nxt)
  );

  sqw_out_gate u_gate (
    .clk_i, .rst_ni, .cfg_i(cfg), .pwr_fail_i,
    .tap_cur_i(tap_cur), .tap_nxt_i(tap_nxt),
    .act_rate_o(act_rate), .sqw_o
  );

  assign rate_o   = cfg.rate;
  assign sqw_en_o = cfg.en;

  AST_RST_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !sqw_o) else $error("reset");  // R1
endmodule

// File: tb/tb_sqw_gen.sv
module tb_sqw_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tick = 1'b0, rate_we = 1'b0, ctrl_we = 1'b0, en_in = 1'b0, pf = 1'b0;
  logic [3:0] rate_in = '0;
  logic [3:0] rate_o;
  logic       en_o, sqw;

  int vectors = 0, fails = 0, tick_div = 1, tick_ctr = 0, ncyc = 0;
  string req = "R1";

  // reference model state
  int m_cnt = 0, m_rate = 0, m_en = 0, m_arate = 0, m_aen = 0, m_sqw = 0;

  sqw_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rate_we_i(rate_we), .rate_i(rate_in),
    .ctrl_we_i(ctrl_we), .sqw_en_i(en_in), .pwr_fail_i(pf),
    .rate_o(rate_o), .sqw_en_o(en_o), .sqw_o(sqw)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int tap(int code, int c);
    int eff, half;
    if (code == 0) return 0;
    eff  = (code < 3) ? code + 7 : code;
    half = 1 << (eff - 2);
    return ((c % (2 * half)) >= half) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rate = 0; m_en = 0; m_arate = 0; m_aen = 0; m_sqw = 0;
    end else begin
      int cn, on, rise, nxt;
      cn = tick ? (m_cnt + 1) % 32768 : m_cnt;
      if (m_sqw == 0) begin m_arate = m_rate; m_aen = m_en; end
      on   = (m_aen != 0 && !pf && m_arate != 0) ? 1 : 0;
      rise = (tap(m_arate, m_cnt) == 0 && tap(m_arate, cn) == 1) ? 1 : 0;
      nxt  = (on != 0 && tap(m_arate, cn) != 0 && (m_sqw != 0 || rise != 0)) ? 1 : 0;
      if (rate_we) m_rate = int'(rate_in);
      if (ctrl_we) m_en = int'(en_in);
      m_cnt = cn;
      m_sqw = nxt;
    end
  end

  task automatic chk(string r, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", r, what, ncyc, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ncyc++;
      chk(req, "sqw_o", int'(sqw), m_sqw);
      chk(req, "rate_o", int'(rate_o), m_rate);
      chk(req, "sqw_en_o", int'(en_o), m_en);
      rate_we = 1'b0;
      ctrl_we = 1'b0;
      tick_ctr++;
      tick = ((tick_ctr % tick_div) == 0);
    end
  endtask

  task automatic set_rate(int code);
    rate_in = 4'(code); rate_we = 1'b1; cyc(1);
  endtask

  task automatic set_en(bit e);
    en_in = e; ctrl_we = 1'b1; cyc(1);
  endtask

  task automatic wait_level(bit lvl, int limit);
    for (int i = 0; i < limit && sqw !== lvl; i++) cyc(1);
  endtask

  initial begin
    // R1: outputs during and right after reset
    repeat (3) @(negedge clk);
    chk("R1", "sqw_o in reset", int'(sqw), 0);
    chk("R1", "rate_o in reset", int'(rate_o), 0);
    chk("R1", "sqw_en_o in reset", int'(en_o), 0);
    rst_n = 1'b1;
    tick  = 1'b1;
    req = "R1"; cyc(4);

    // R10: register readback
    req = "R10"; set_rate(5); set_en(1'b1); cyc(2);
    chk("R10", "rate readback", int'(rate_o), 5);
    chk("R10", "en readback", int'(en_o), 1);

    // R3: straight taps, fastest, mid, slowest over whole periods
    req = "R3"; cyc(100);
    set_rate(3); cyc(64);
    set_rate(6); cyc(200);
    set_rate(11); cyc(4200);
    set_rate(15); cyc(33000);

    // R4: aliased low codes against their twins
    req = "R4"; set_rate(1); cyc(600);
    set_rate(8); cyc(400);
    set_rate(2); cyc(800);
    set_rate(9); cyc(600);

    // R5: code 0 holds low
    req = "R5"; set_rate(0); cyc(300);
    chk("R5", "code0 low", int'(sqw), 0);

    // R6 / R8: disable, then enable mid-high so the first pulse must wait
    req = "R6"; set_rate(5); cyc(40); set_en(1'b0); cyc(200);
    chk("R6", "disabled low", int'(sqw), 0);
    req = "R8";
    for (int k = 0; k < 6; k++) begin
      set_en(1'b0); cyc(37 + k * 3);
      set_en(1'b1); cyc(60);
    end

    // R7: power-fail drops the pin regardless of enable
    req = "R7"; set_rate(4);
    for (int k = 0; k < 5; k++) begin
      cyc(11 + k); pf = 1'b1; cyc(1);
      chk("R7", "pf low", int'(sqw), 0);
      cyc(5 + k); pf = 1'b0; cyc(30);
    end

    // R9: rate/enable written while high wait for the low phase
    req = "R9"; set_rate(7); cyc(10);
    for (int k = 0; k < 4; k++) begin
      wait_level(1'b1, 300); cyc(3 + k);
      set_rate((k % 2) ? 7 : 3); cyc(5);
      set_rate((k % 2) ? 4 : 10); cyc(400);
    end
    wait_level(1'b1, 300); set_en(1'b0); cyc(300);
    set_en(1'b1);

    // R2: sparse strobes, divider keeps counting while off
    req = "R2"; tick_div = 3; set_rate(4); cyc(300);
    set_en(1'b0); cyc(157); set_en(1'b1); cyc(300);
    tick_div = 5; set_rate(3); cyc(200);
    tick_div = 1; cyc(50);

    // R1: reset in the middle of activity
    req = "R1";
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "sqw_o mid reset", int'(sqw), 0);
    chk("R1", "en mid reset", int'(en_o), 0);
    chk("R1", "rate mid reset", int'(rate_o), 0);
    rst_n = 1'b1; cyc(20);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    fails++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", ncyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule